// File: doc/BRIEF.md
# Banked GPIO Controller with Half-Word Masked Data Ports

This block is a memory-mapped general-purpose I/O controller. It serves a set of pin banks, and each bank holds up to 32 pins. Software reaches it over a plain 32-bit register bus made of an address, a write strobe, write data and combinational read data. Each bank keeps three stored registers: output data, direction and output enable. It also has a read-only view of the pin input levels, which pass through a two-flop synchronizer before they can be read.

Output data is never written as a full word. Each bank has two data ports, one for pins 0–15 and one for pins 16–31. In a write to either port, the upper 16 bits of the bus word act as an active-low mask over the lower 16 data bits. Software can therefore change single pins without reading the register first.

Bank numbering is sparse. The default layout has five bank slots holding 26, 26, 0, 32 and 32 pins, which gives 116 pins in total. Two pins of bank 0 are configured as permanent outputs.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every data and output-enable register is 0, every direction bit is 0 except the forced bits of R8, and `pin_oe` is all zero.
- R2: A write to the lower data port of bank b (address 8*b) updates data bit i (i = 0..15) from wdata[i] only where wdata[16+i] is 0. Where wdata[16+i] is 1, the stored bit is kept.
- R3: A write to the upper data port of bank b (address 8*b + 4) applies the same masked rule to pins 16..31. Bus bit i maps to pin 16+i.
- R4: Reading a data port returns the stored half for that port in bits [15:0], and bits [31:16] read as 0.
- R5: The direction register of bank b (address 0x204 + 0x40*b) is readable and writable. Bit value 1 means output.
- R6: The output-enable register of bank b is at address 0x208 + 0x40*b. A pin's `pin_oe` is 1 only when both its direction bit and its enable bit are 1. `pin_out` carries the stored data bit. Neither output changes in a cycle that follows no bus write.
- R7: The input register of bank b (address 0x60 + 4*b) returns the pin levels delayed by two clock edges. Writes to it have no effect.
- R8: Direction bits 7 and 8 of bank 0 read as 1 at all times after reset. A write of 0 to them is ignored.
- R9: Bank 2 has no pins, so all its addresses read 0 and ignore writes. Register bits at or above a bank's pin count read 0 and ignore writes.
- R10: Pins are packed in bank order on the pin vectors: bank 0 on bits 0..25, bank 1 on bits 26..51, bank 3 on bits 52..83 and bank 4 on bits 84..115.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (12) | Register byte address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | TOTAL_PINS (116) | Pin input levels |
| pin_out | output | TOTAL_PINS (116) | Per-pin drive value |
| pin_oe | output | TOTAL_PINS (116) | Per-pin drive enable |

## Verification
The bound checker tests several properties on every cycle:
- reads from the empty bank return zero;
- register bits beyond a bank's pin count stay zero;
- the upper half of a data-port read is zero;
- the forced direction bits of bank 0 always read back as 1;
- the drive outputs stay unchanged when no write happened in the previous cycle.

Only the bench scenarios show the rest:
- the masked merge itself;
- the mapping of the upper port onto pins 16–31;
- the combination of direction with enable;
- the exact two-edge input latency and the pin packing.

The bench shows these by comparing against its behavioural model on each clock and through directed checks.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   localparam int unsigned MAX_BANKS   = 8;
   localparam int unsigned REG_W       = 32;
   localparam int unsigned HALF_W      = 16;
   localparam int unsigned DATA_STRIDE = 8;
   localparam int unsigned IN_BASE     = 'h60;
   localparam int unsigned IN_STRIDE   = 4;
   localparam int unsigned DIR_BASE    = 'h204;
   localparam int unsigned OEN_BASE    = 'h208;
   localparam int unsigned CFG_STRIDE  = 'h40;

   // pin count of bank b, one byte per bank in the packed list
   function automatic int unsigned width_of(input logic [8*MAX_BANKS-1:0] widths,
                                            input int unsigned b);
      return int'(widths[b*8 +: 8]);
   endfunction

   // first pin index of bank b on the packed pin vectors
   function automatic int unsigned pin_base(input logic [8*MAX_BANKS-1:0] widths,
                                            input int unsigned b);
      int unsigned s;
      s = 0;
      for (int unsigned k = 0; k < MAX_BANKS; k++)
         if (k < b) s += int'(widths[k*8 +: 8]);
      return s;
   endfunction

   function automatic int unsigned pin_total(input logic [8*MAX_BANKS-1:0] widths,
                                             input int unsigned n);
      return pin_base(widths, n);
   endfunction

   function automatic logic [REG_W-1:0] width_mask(input int unsigned w);
      if (w >= REG_W) return '1;
      return (REG_W'(1) << w) - REG_W'(1);
   endfunction

   // active-low mask in the upper half selects which data bits are taken
   function automatic logic [HALF_W-1:0] merge_half(input logic [HALF_W-1:0] old,
                                                    input logic [REG_W-1:0]  word);
      return (old & word[REG_W-1:HALF_W]) | (word[HALF_W-1:0] & ~word[REG_W-1:HALF_W]);
   endfunction
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("gpio_sync2: STAGES must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain[0] <= d;
         for (int unsigned s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs #(
   parameter int unsigned WIDTH      = 32,
   parameter logic [31:0] FORCE_MASK = '0,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_lo,
   input  logic        wr_hi,
   input  logic        wr_dir,
   input  logic        wr_oen,
   input  logic [31:0] wdata,
   input  logic [31:0] pad_in,
   output logic [31:0] data_q,
   output logic [31:0] dir_q,
   output logic [31:0] oen_q,
   output logic [31:0] in_q
);
   import gpio_bank_pkg::*;

   localparam logic [31:0] VMASK = width_mask(WIDTH);
   localparam logic [31:0] FMASK = FORCE_MASK & VMASK;

   generate
      if (WIDTH < 1 || WIDTH > REG_W) begin : g_bad_width
         $error("gpio_bank_regs: WIDTH out of range");
      end
   endgenerate

   logic [31:0] data_d;

   always_comb begin
      data_d = data_q;
      if (wr_lo) data_d[15:0]  = merge_half(data_q[15:0], wdata) & VMASK[15:0];
      if (wr_hi) data_d[31:16] = merge_half(data_q[31:16], wdata) & VMASK[31:16];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         dir_q  <= FMASK;
         oen_q  <= '0;
      end else begin
         data_q <= data_d;
         if (wr_dir) dir_q <= (wdata & VMASK) | FMASK;
         if (wr_oen) oen_q <= wdata & VMASK;
      end
   end

   gpio_sync2 #(.W(32), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in & VMASK),
      .q     (in_q)
   );
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl #(
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned BANK_CNT    = 5,
   parameter logic [63:0] BANK_WIDTHS = 64'h0000_0020_2000_1A1A,
   parameter int unsigned FORCE_BANK  = 0,
   parameter logic [31:0] FORCE_MASK  = 32'h0000_0180,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned TOTAL_PINS  = gpio_bank_pkg::pin_total(BANK_WIDTHS, BANK_CNT)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic                  bus_we,
   input  logic [31:0]           bus_wdata,
   output logic [31:0]           bus_rdata,
   input  logic [TOTAL_PINS-1:0] pin_in,
   output logic [TOTAL_PINS-1:0] pin_out,
   output logic [TOTAL_PINS-1:0] pin_oe
);
   import gpio_bank_pkg::*;

   localparam int unsigned LAST_CFG = OEN_BASE + CFG_STRIDE * (BANK_CNT - 1);

   generate
      if (BANK_CNT < 1 || BANK_CNT > MAX_BANKS) begin : g_bad_cnt
         $error("gpio_bank_ctrl: BANK_CNT out of range");
      end
      if (FORCE_BANK >= BANK_CNT) begin : g_bad_force
         $error("gpio_bank_ctrl: FORCE_BANK beyond last bank");
      end
      if (TOTAL_PINS != pin_total(BANK_WIDTHS, BANK_CNT)) begin : g_bad_total
         $error("gpio_bank_ctrl: TOTAL_PINS does not match BANK_WIDTHS");
      end
      if (LAST_CFG >= (1 << ADDR_W)) begin : g_bad_addr
         $error("gpio_bank_ctrl: ADDR_W too narrow for the register map");
      end
   endgenerate

   logic [31:0] rd_vec [BANK_CNT];

   generate
      for (genvar b = 0; b < BANK_CNT; b++) begin : g_bank
         localparam int unsigned W    = width_of(BANK_WIDTHS, b);
         localparam int unsigned BASE = pin_base(BANK_WIDTHS, b);
         localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(DATA_STRIDE * b);
         localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(DATA_STRIDE * b + 4);
         localparam logic [ADDR_W-1:0] A_IN  = ADDR_W'(IN_BASE + IN_STRIDE * b);
         localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(DIR_BASE + CFG_STRIDE * b);
         localparam logic [ADDR_W-1:0] A_OEN = ADDR_W'(OEN_BASE + CFG_STRIDE * b);

         if (W > REG_W) begin : g_bad_w
            $error("gpio_bank_ctrl: a bank is wider than a register");
         end

         if (W == 0) begin : g_absent
            // empty slot: no storage, reads are zero, writes vanish
            assign rd_vec[b] = '0;
         end else begin : g_present
            logic [31:0] data_q, dir_q, oen_q, in_q, pad;

            always_comb begin
               pad = '0;
               pad[W-1:0] = pin_in[BASE +: W];
            end

            gpio_bank_regs #(
               .WIDTH       (W),
               .FORCE_MASK  ((b == FORCE_BANK) ? FORCE_MASK : 32'h0),
               .SYNC_STAGES (SYNC_STAGES)
            ) u_regs (
               .clk    (clk),
               .rst_n  (rst_n),
               .wr_lo  (bus_we && bus_addr == A_LO),
               .wr_hi  (bus_we && bus_addr == A_HI),
               .wr_dir (bus_we && bus_addr == A_DIR),
               .wr_oen (bus_we && bus_addr == A_OEN),
               .wdata  (bus_wdata),
               .pad_in (pad),
               .data_q (data_q),
               .dir_q  (dir_q),
               .oen_q  (oen_q),
               .in_q   (in_q)
            );

            assign pin_out[BASE +: W] = data_q[W-1:0];
            assign pin_oe[BASE +: W]  = dir_q[W-1:0] & oen_q[W-1:0];

            always_comb begin
               unique case (bus_addr)
                  A_LO:    rd_vec[b] = {16'h0, data_q[15:0]};
                  A_HI:    rd_vec[b] = {16'h0, data_q[31:16]};
                  A_IN:    rd_vec[b] = in_q;
                  A_DIR:   rd_vec[b] = dir_q;
                  A_OEN:   rd_vec[b] = oen_q;
                  default: rd_vec[b] = '0;
               endcase
            end
         end
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      for (int unsigned b = 0; b < BANK_CNT; b++) bus_rdata |= rd_vec[b];
   end
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned BANK_CNT    = 5,
   parameter logic [63:0] BANK_WIDTHS = 64'h0000_0020_2000_1A1A,
   parameter int unsigned FORCE_BANK  = 0,
   parameter logic [31:0] FORCE_MASK  = 32'h0000_0180,
   parameter int unsigned TOTAL_PINS  = 116
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [ADDR_W-1:0]     bus_addr,
   input logic                  bus_we,
   input logic [31:0]           bus_rdata,
   input logic [TOTAL_PINS-1:0] pin_out,
   input logic [TOTAL_PINS-1:0] pin_oe
);
   import gpio_bank_pkg::*;

   // R1: while reset is held no pin is driven
   always @(posedge clk) begin
      if (!rst_n) a_r1_reset_no_drive: assert (pin_oe == '0);
   end

   // R6: drive outputs only move after a bus write
   a_r6_drive_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bus_we) |-> ($stable(pin_oe) && $stable(pin_out)));

   generate
      for (genvar b = 0; b < BANK_CNT; b++) begin : g_chk
         localparam int unsigned W = width_of(BANK_WIDTHS, b);
         localparam logic [31:0] VMASK = width_mask(W);
         localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(DATA_STRIDE * b);
         localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(DATA_STRIDE * b + 4);
         localparam logic [ADDR_W-1:0] A_IN  = ADDR_W'(IN_BASE + IN_STRIDE * b);
         localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(DIR_BASE + CFG_STRIDE * b);
         localparam logic [ADDR_W-1:0] A_OEN = ADDR_W'(OEN_BASE + CFG_STRIDE * b);

         if (W == 0) begin : g_absent
            // R9: empty bank slot reads zero
            a_r9_absent_bank_zero: assert property (@(posedge clk) disable iff (!rst_n)
               (bus_addr == A_LO || bus_addr == A_HI || bus_addr == A_IN ||
                bus_addr == A_DIR || bus_addr == A_OEN) |-> (bus_rdata == '0));
         end else begin : g_present
            // R4: data-port reads leave the mask half at zero
            a_r4_half_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
               (bus_addr == A_LO || bus_addr == A_HI) |-> (bus_rdata[31:16] == 16'h0));
            if (W < 32) begin : g_narrow
               // R9: bits past the pin count stay zero
               a_r9_beyond_width_zero: assert property (@(posedge clk) disable iff (!rst_n)
                  (bus_addr == A_IN || bus_addr == A_DIR || bus_addr == A_OEN)
                  |-> ((bus_rdata & ~VMASK) == '0));
            end
            if (b == FORCE_BANK) begin : g_forced
               // R8: forced direction bits always read as outputs
               a_r8_forced_dir_set: assert property (@(posedge clk) disable iff (!rst_n)
                  (bus_addr == A_DIR) |-> ((bus_rdata & FORCE_MASK & VMASK) == (FORCE_MASK & VMASK)));
            end
         end
      end
   endgenerate
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(
   .ADDR_W      (ADDR_W),
   .BANK_CNT    (BANK_CNT),
   .BANK_WIDTHS (BANK_WIDTHS),
   .FORCE_BANK  (FORCE_BANK),
   .FORCE_MASK  (FORCE_MASK),
   .TOTAL_PINS  (TOTAL_PINS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .bus_rdata (bus_rdata),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe)
);

// File: tb/test_gpio_bank_ctrl.sv
`timescale 1ns/1ps
module test_gpio_bank_ctrl;
   localparam int NP = 116;
   localparam int NB = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [11:0]   addr = '0;
   logic          we = 1'b0;
   logic [31:0]   wd = '0;
   logic [31:0]   rdata;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_out, pin_oe;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;   // 125 MHz

   gpio_bank_ctrl i_gpio_bank_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wd),
      .bus_rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   // ---------------- behavioural reference model ----------------
   int          bw [NB] = '{26, 26, 0, 32, 32};
   int          bb [NB] = '{0, 26, 52, 52, 84};
   bit [31:0]   m_data [NB];
   bit [31:0]   m_dir  [NB];
   bit [31:0]   m_oen  [NB];
   bit [NP-1:0] s1, s2;

   function automatic bit [31:0] vmask(int w);
      return (w >= 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 1);
   endfunction

   function automatic void model_reset();
      for (int b = 0; b < NB; b++) begin
         m_data[b] = 0; m_oen[b] = 0;
         m_dir[b]  = (b == 0) ? 32'h180 : 32'h0;
      end
      s1 = '0; s2 = '0;
   endfunction

   function automatic void model_write(bit [11:0] a, bit [31:0] d);
      for (int b = 0; b < NB; b++) begin
         bit [31:0] vm;
         bit [15:0] m;
         if (bw[b] == 0) continue;
         vm = vmask(bw[b]);
         m  = d[31:16];
         if (a == 12'(8*b))
            m_data[b][15:0] = ((m_data[b][15:0] & m) | (d[15:0] & ~m)) & vm[15:0];
         if (a == 12'(8*b+4))
            m_data[b][31:16] = ((m_data[b][31:16] & m) | (d[15:0] & ~m)) & vm[31:16];
         if (a == 12'('h204 + 'h40*b))
            m_dir[b] = (d & vm) | ((b == 0) ? 32'h180 : 32'h0);
         if (a == 12'('h208 + 'h40*b))
            m_oen[b] = d & vm;
      end
   endfunction

   function automatic bit [31:0] model_read(bit [11:0] a);
      for (int b = 0; b < NB; b++) begin
         if (bw[b] == 0) continue;
         if (a == 12'(8*b))   return {16'h0, m_data[b][15:0]};
         if (a == 12'(8*b+4)) return {16'h0, m_data[b][31:16]};
         if (a == 12'('h60 + 4*b)) begin
            bit [31:0] v = 0;
            for (int i = 0; i < bw[b]; i++) v[i] = s2[bb[b]+i];
            return v;
         end
         if (a == 12'('h204 + 'h40*b)) return m_dir[b];
         if (a == 12'('h208 + 'h40*b)) return m_oen[b];
      end
      return 0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else begin
         if (we) model_write(addr, wd);
         s2 = s1;
         s1 = pin_in;
      end
   end

   // per-clock comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [NP-1:0] eo, ee;
         for (int b = 0; b < NB; b++)
            for (int i = 0; i < bw[b]; i++) begin
               eo[bb[b]+i] = m_data[b][i];
               ee[bb[b]+i] = m_dir[b][i] & m_oen[b][i];
            end
         checks++;
         if (pin_out !== eo || pin_oe !== ee || rdata !== model_read(addr)) begin
            errors++;
            $display("FAIL R6 R10 per-cycle model: out=%h oe=%h rd=%h exp out=%h oe=%h rd=%h",
                     pin_out, pin_oe, rdata, eo, ee, model_read(addr));
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      @(posedge clk); #1; addr = a; wd = d; we = 1'b1;
      @(posedge clk); #1; we = 1'b0;
      @(negedge clk);
   endtask

   task automatic rd(logic [11:0] a);
      @(posedge clk); #1; addr = a; we = 1'b0;
      @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(8 * 100000);
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 / R8 reset state
      rd(12'h204); chk("R1 R8 bank0 dir after reset", rdata, 32'h180);
      rd(12'h000); chk("R1 data after reset", rdata, 32'h0);
      chk("R1 no pin driven", {31'h0, |pin_oe}, 32'h0);

      // R2 masked low half
      wr(12'h000, 32'hFF00_00A5); rd(12'h000); chk("R2 low byte written", rdata, 32'hA5);
      wr(12'h000, 32'hFFF0_0003); rd(12'h000); chk("R2 nibble merge", rdata, 32'hA3);
      wr(12'h000, 32'hFFFF_1234); rd(12'h000); chk("R2 R4 full mask keeps data", rdata, 32'hA3);

      // R3 / R10 upper port of bank 3
      wr(12'h01C, 32'h0000_BEEF); rd(12'h01C); chk("R3 upper half read", rdata, 32'hBEEF);
      chk("R3 R10 bank3 pins 16..31", 32'(pin_out[68 +: 16]), 32'hBEEF);
      rd(12'h018); chk("R3 lower half untouched", rdata, 32'h0);

      // R9 width clipping on bank 0 upper half
      wr(12'h004, 32'h0000_FFFF); rd(12'h004); chk("R9 bank0 upper clipped", rdata, 32'h3FF);

      // R8 forced direction bits
      wr(12'h204, 32'h0); rd(12'h204); chk("R8 clear ignored", rdata, 32'h180);

      // R5 direction register, clipped to 26 bits
      wr(12'h244, 32'hFFFF_FFFF); rd(12'h244); chk("R5 R9 bank1 dir", rdata, 32'h03FF_FFFF);

      // R6 drive enable needs direction and enable
      wr(12'h248, 32'h0000_000F);
      chk("R6 bank1 oe both set", 32'(pin_oe[26 +: 4]), 32'hF);
      wr(12'h008, 32'h0000_000A);
      chk("R6 R10 bank1 drive value", 32'(pin_out[26 +: 4]), 32'hA);
      wr(12'h244, 32'h0000_0005);
      chk("R6 dir gates oe", 32'(pin_oe[26 +: 4]), 32'h5);
      wr(12'h208, 32'h0000_0180);
      chk("R6 R8 bank0 forced pins driven", 32'(pin_oe[8:7]), 32'h3);

      // R9 absent bank 2
      wr(12'h284, 32'hFFFF_FFFF); rd(12'h284); chk("R9 absent dir", rdata, 32'h0);
      wr(12'h010, 32'h0000_FFFF); rd(12'h010); chk("R9 absent data", rdata, 32'h0);
      rd(12'h068); chk("R9 absent input", rdata, 32'h0);

      // R7 two-edge input latency on bank 4
      @(posedge clk); #1; addr = 12'h070; pin_in[84 +: 32] = 32'h1234_5678;
      @(negedge clk); chk("R7 before first edge", rdata, 32'h0);
      @(negedge clk); chk("R7 after one edge", rdata, 32'h0);
      @(negedge clk); chk("R7 after two edges", rdata, 32'h1234_5678);
      wr(12'h070, 32'h0); rd(12'h070); chk("R7 input write ignored", rdata, 32'h1234_5678);

      // R10 bank 1 first pin lands in bank 1 input bit 0
      @(posedge clk); #1; pin_in[26] = 1'b1;
      repeat (3) @(negedge clk);
      rd(12'h064); chk("R10 bank1 pin0 input", rdata, 32'h1);
      rd(12'h060); chk("R10 bank0 input clear", rdata, 32'h0);

      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule